// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the register side of a platform-level interrupt controller. A request/response bus reaches three register areas through it. The first holds one priority per interrupt source. The second holds one enable bitmap per context. The third holds one threshold and one claim/complete register per context. The block also keeps a pending bit and an in-service bit for every source. From these it works out, for each context, which source a claim would return, and it raises that context's interrupt line whenever that answer is not zero.

Accesses are 4 or 8 bytes wide. An 8-byte access runs as two word accesses, one after the other. Any narrower access gets an error response. Addresses that are reserved, misaligned or out of range never produce an error: they read as zero and ignore writes. Both bus channels use valid/ready. The request fields must stay stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only when no access is in progress or waiting to be accepted. A response stays on `rsp_valid`, `rsp_rdata` and `rsp_err`, unchanged, until the cycle in which `rsp_ready` is high. A 4-byte request gives its response two cycles after acceptance. An 8-byte request gives it three cycles after acceptance. A rejected size gives it one cycle after acceptance.

Address map (16-bit byte address):
- Priority of source N: byte `4*N`, for N from 0 to 1023.
- Enable word w of context c: byte `0x2000 + 0x80*c + 4*w`. Bit b of that word is source `32*w + b`.
- Threshold of context c: byte `0x8000 + 0x100*c`.
- Claim/complete register of context c: byte `0x8004 + 0x100*c`.

Top module: `plic_fe`

## Requirements
- R1: Bus size and word lane rules. `req_size` 2 selects 4 bytes. `req_size` 3 selects 8 bytes. A 4-byte access uses `req_wdata[31:0]`, and its read data appears in `rsp_rdata[31:0]` with the upper half zero. Every write response carries `rsp_rdata` equal to zero.
- R2: The priority of source N is at byte address `4*N`. A write stores only the low `PRIO_W` bits of the data. A read returns the stored value zero-extended. All priorities reset to 0.
- R3: The following all read as zero, ignore writes and respond with `rsp_err`=0: the priority of source 0, and priority words for N >= `NSRC`.
- R4: The enable word w of context c is at `0x2000 + 0x80*c + 4*w`, and bit b is source `32*w+b`. Bit 0 of word 0 always reads 0, whatever was written. Bits for sources >= `NSRC` also read 0.
- R5: The following all read as zero, ignore writes and respond with `rsp_err`=0: enable words at or beyond `ceil(NSRC/32)`, offsets in a context block other than 0 and 4, contexts >= `NCTX`, unmapped addresses, and addresses whose two low bits are not zero.
- R6: The threshold of context c is at `0x8000 + 0x100*c`. It is stored masked to `PRIO_W` bits and resets to 0.
- R7: Reading `0x8004 + 0x100*c` returns the source that is pending, enabled in context c and has the highest priority strictly above the threshold of c. A tie goes to the lowest ID. The read clears that source's pending bit. The read returns 0, with no side effect, when no such source exists.
- R8: A `src_pend` pulse sets the pending bit of a source only while that source is not in service. A claim puts the source in service. Writing the source ID to the claim/complete register of any context takes it out of service. Writes of 0 or of IDs >= `NSRC` there have no effect.
- R9: `irq_ctx[c]` is high exactly when a claim from context c would return a nonzero ID. It is low after reset.
- R10: A `req_size` of 0 or 1 is rejected. The response has `rsp_err`=1 and `rsp_rdata`=0, and no register changes.
- R11: An 8-byte access performs a word access at the address using `req_wdata[31:0]` and `rsp_rdata[31:0]`. It then performs a word access at address+4 using the upper halves. Any side effects, such as claim or complete, happen in that order.
- R12: `req_ready` is low while a response is outstanding. `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady until `rsp_ready` is high. Every accepted request yields exactly one response, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NSRC-1 | Per-source pending request pulse, bit k is source k (sources 1..NSRC-1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size code (2 = 4 bytes, 3 = 8 bytes) |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted when high with rsp_valid |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access rejected |
| irq_ctx | output | NCTX | Per-context interrupt request |

## Verification
The hardest situation to reach from the ports is a source that is in service when a new request arrives. A pulse that lands then must be dropped, not remembered. The bench reaches this state by claiming a source, pulsing its pending input again, and showing that the next claim returns zero. Only then does it complete the source, through another context's register, and show that a fresh pulse makes it claimable again. A second hard case is the threshold tie. A source whose priority equals the threshold is pending, yet the interrupt line stays low until the threshold is lowered by one. Double-word claim reads and complete writes check that the low half takes effect before the high half. The response channel is stalled every third cycle throughout the run.

// File: rtl/plic_fe_pkg.sv
package plic_fe_pkg;

  localparam int ADDR_W = 16;
  localparam int BUS_W  = 64;
  localparam int WORD_W = 32;

  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_RSP
  } bus_st_e;

endpackage

// File: rtl/plic_fe_decode.sv
module plic_fe_decode
  import plic_fe_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int NCTX   = 2,
  parameter int IDW    = 6,
  parameter int WW     = 1,
  parameter int CW     = 1,
  parameter int NWORDS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDW-1:0]    src_o,
  output logic [WW-1:0]     word_o,
  output logic [CW-1:0]     ctx_o
);

  localparam logic [10:0] SRC_LIM  = 11'(NSRC);
  localparam logic [5:0]  WORD_LIM = 6'(NWORDS);
  localparam logic [5:0]  ENC_LIM  = 6'(NCTX);
  localparam logic [7:0]  CXC_LIM  = 8'(NCTX);

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    kind_o = RK_NONE;
    src_o  = addr_i[2 +: IDW];
    word_o = addr_i[2 +: WW];
    ctx_o  = '0;
    if (addr_i[15]) begin
      // context block: threshold at word 0, claim/complete at word 1
      ctx_o = addr_i[8 +: CW];
      if (aligned && ({1'b0, addr_i[14:8]} < CXC_LIM)) begin
        case (addr_i[7:2])
          6'd0:    kind_o = RK_THR;
          6'd1:    kind_o = RK_CLAIM;
          default: kind_o = RK_NONE;
        endcase
      end
    end else if (addr_i[14:12] == 3'd2) begin
      ctx_o = addr_i[7 +: CW];
      if (aligned && ({1'b0, addr_i[11:7]} < ENC_LIM) &&
          ({1'b0, addr_i[6:2]} < WORD_LIM))
        kind_o = RK_EN;
    end else if (addr_i[14:12] == 3'd0) begin
      if (aligned && (addr_i[11:2] != 10'd0) &&
          ({1'b0, addr_i[11:2]} < SRC_LIM))
        kind_o = RK_PRIO;
    end
  end

endmodule

// File: rtl/plic_fe_gateway.sv
module plic_fe_gateway #(
  parameter int NSRC = 40,
  parameter int IDW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:1] set_i,
  input  logic            claim_en_i,
  input  logic [IDW-1:0]  claim_id_i,
  input  logic            done_en_i,
  input  logic [IDW-1:0]  done_id_i,
  output logic [NSRC-1:1] pend_o
);

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    logic pend_q;
    logic busy_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (claim_en_i && (claim_id_i == IDW'(i))) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
      end else begin
        if (set_i[i] && !busy_q)
          pend_q <= 1'b1;
        if (done_en_i && (done_id_i == IDW'(i)))
          busy_q <= 1'b0;
      end
    end

    assign pend_o[i] = pend_q;
  end

endmodule

// File: rtl/plic_fe_arbiter.sv
module plic_fe_arbiter #(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 3,
  parameter int IDW    = 6
) (
  input  logic [NSRC-1:1]             elig_i,
  input  logic [NSRC-1:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [IDW-1:0]              id_o
);

  logic [PRIO_W-1:0] best_p;

  // strict compare: ties keep the lower ID, equal-to-threshold never wins
  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig_i[i] && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        id_o   = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/plic_fe.sv
module plic_fe
  import plic_fe_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:1]   src_pend,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [15:0]       req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCTX-1:0]   irq_ctx
);

  localparam int IDW    = $clog2(NSRC);
  localparam int NWORDS = (NSRC + WORD_W - 1) / WORD_W;
  localparam int WW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int CW     = (NCTX > 1) ? $clog2(NCTX) : 1;

  // register state
  logic [NSRC-1:1][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC-1:1]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NSRC-1:1]             pend;
  logic [NCTX-1:0][IDW-1:0]    best;

  // bus sequencing state
  bus_st_e            st_q;
  logic               wr_q;
  logic               dw_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BUS_W-1:0]   wdata_q;
  logic [BUS_W-1:0]   rdata_q;
  logic               err_q;

  logic               active;
  logic [ADDR_W-1:0]  cur_addr;
  logic [WORD_W-1:0]  cur_wdata;
  logic [WORD_W-1:0]  rd_word;

  reg_kind_e          kind;
  logic [IDW-1:0]     src_id;
  logic [WW-1:0]      word;
  logic [CW-1:0]      ctx;

  logic               claim_en;
  logic               done_en;
  logic [IDW-1:0]     done_id;

  assign active    = (st_q == ST_LO) || (st_q == ST_HI);
  assign cur_addr  = (st_q == ST_HI) ? (addr_q + ADDR_W'(4)) : addr_q;
  assign cur_wdata = (st_q == ST_HI) ? wdata_q[63:32] : wdata_q[31:0];

  plic_fe_decode #(
    .NSRC(NSRC), .NCTX(NCTX), .IDW(IDW), .WW(WW), .CW(CW), .NWORDS(NWORDS)
  ) u_dec (
    .addr_i (cur_addr),
    .kind_o (kind),
    .src_o  (src_id),
    .word_o (word),
    .ctx_o  (ctx)
  );

  // read side of the current word
  always_comb begin
    rd_word = '0;
    case (kind)
      RK_PRIO:  rd_word = WORD_W'(prio_q[src_id]);
      RK_EN: begin
        for (int b = 0; b < WORD_W; b++) begin
          if ((int'(word) * WORD_W + b >= 1) && (int'(word) * WORD_W + b < NSRC))
            rd_word[b] = en_q[ctx][int'(word) * WORD_W + b];
        end
      end
      RK_THR:   rd_word = WORD_W'(thr_q[ctx]);
      RK_CLAIM: rd_word = WORD_W'(best[ctx]);
      default:  rd_word = '0;
    endcase
  end

  // write side of the current word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (active && wr_q) begin
      case (kind)
        RK_PRIO: prio_q[src_id] <= cur_wdata[PRIO_W-1:0];
        RK_EN: begin
          for (int b = 0; b < WORD_W; b++) begin
            if ((int'(word) * WORD_W + b >= 1) && (int'(word) * WORD_W + b < NSRC))
              en_q[ctx][int'(word) * WORD_W + b] <= cur_wdata[b];
          end
        end
        RK_THR:  thr_q[ctx] <= cur_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // claim on read, complete on write
  assign claim_en = active && !wr_q && (kind == RK_CLAIM) && (best[ctx] != '0);
  assign done_en  = active && wr_q && (kind == RK_CLAIM) &&
                    (cur_wdata != '0) && (cur_wdata < WORD_W'(NSRC));
  assign done_id  = cur_wdata[IDW-1:0];

  plic_fe_gateway #(.NSRC(NSRC), .IDW(IDW)) u_gw (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (src_pend),
    .claim_en_i (claim_en),
    .claim_id_i (best[ctx]),
    .done_en_i  (done_en),
    .done_id_i  (done_id),
    .pend_o     (pend)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    plic_fe_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .elig_i (en_q[c] & pend),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (best[c])
    );
    assign irq_ctx[c] = (best[c] != '0);
  end

  // request/response sequencer: one word access per cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      dw_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            dw_q    <= (req_size == SZ_DWORD);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            if ((req_size == SZ_WORD) || (req_size == SZ_DWORD)) begin
              err_q <= 1'b0;
              st_q  <= ST_LO;
            end else begin
              err_q <= 1'b1;
              st_q  <= ST_RSP;
            end
          end
        end
        ST_LO: begin
          rdata_q[31:0] <= wr_q ? '0 : rd_word;
          st_q          <= dw_q ? ST_HI : ST_RSP;
        end
        ST_HI: begin
          rdata_q[63:32] <= wr_q ? '0 : rd_word;
          st_q           <= ST_RSP;
        end
        default: begin
          if (rsp_ready)
            st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RSP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/plic_fe_chk.sv
module plic_fe_chk #(
  parameter int NSRC = 40,
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_size,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [63:0]     rsp_rdata,
  input logic            rsp_err,
  input logic [NCTX-1:0] irq_ctx,
  input logic [NSRC-1:1] pend_i
);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_reject_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_size[1]) |=> (rsp_valid && rsp_err && (rsp_rdata == 64'd0)));

  a_r1_word_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size == 2'd2)) |=> !rsp_valid ##1 (rsp_valid && !rsp_err));

  a_r11_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_size == 2'd3)) |=> !rsp_valid ##1 !rsp_valid ##1 (rsp_valid && !rsp_err));

  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ctx) |-> (|pend_i));

endmodule

bind plic_fe plic_fe_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .irq_ctx   (irq_ctx),
  .pend_i    (pend)
);

// File: tb/plic_fe_test.sv
`timescale 1ns/1ps
module plic_fe_test;

  localparam int NSRC = 40;
  localparam int NCTX = 2;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:1] src_pend;
  logic            req_valid;
  logic            req_ready;
  logic            req_write;
  logic [1:0]      req_size;
  logic [15:0]     req_addr;
  logic [63:0]     req_wdata;
  logic            rsp_valid;
  logic            rsp_ready;
  logic [63:0]     rsp_rdata;
  logic            rsp_err;
  logic [NCTX-1:0] irq_ctx;

  plic_fe #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq_ctx(irq_ctx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [63:0] exp_d[$];
  logic        exp_e[$];
  string       exp_t[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: stalls the response channel every third cycle, pops the scoreboard
  always @(negedge clk) begin
    cyc++;
    rsp_ready = (cyc % 3) != 1;
    if (rst_n && rsp_valid) begin
      check("R12 req_ready low while response pending", 64'(req_ready), 64'd0);
      if (rsp_ready) begin
        if (exp_d.size() == 0) begin
          check("R12 unexpected response", 64'd1, 64'd0);
        end else begin
          logic [63:0] d;
          logic        e;
          string       t;
          d = exp_d.pop_front();
          e = exp_e.pop_front();
          t = exp_t.pop_front();
          check({t, " data"}, rsp_rdata, d);
          check({t, " err"}, 64'(rsp_err), 64'(e));
        end
      end
    end
  end

  task automatic bus(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                     input logic [63:0] wd, input logic [63:0] ed, input logic ee,
                     input string tag);
    exp_d.push_back(ed);
    exp_e.push_back(ee);
    exp_t.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = a;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd32(input logic [15:0] a, input logic [31:0] e, input string tag);
    bus(1'b0, 2'd2, a, 64'd0, 64'(e), 1'b0, tag);
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] d, input string tag);
    bus(1'b1, 2'd2, a, 64'(d), 64'd0, 1'b0, tag);
  endtask

  task automatic drain();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NSRC-1:1] sbit(input int s);
    logic [NSRC-1:1] m;
    m = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  task automatic pulse(input logic [NSRC-1:1] m);
    @(negedge clk);
    src_pend = m;
    @(negedge clk);
    src_pend = '0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: got hang expected all responses");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; src_pend = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 irq low after reset", 64'(irq_ctx), 64'd0);
    rd32(16'h0014, 32'd0, "R2 priority reset value");

    // priorities
    wr32(16'h0014, 32'hFF, "R2 write prio5");
    rd32(16'h0014, 32'd7, "R2 prio masked to width");
    wr32(16'h000C, 32'd2, "R2 prio3");
    wr32(16'h001C, 32'd2, "R2 prio7");
    wr32(16'h0024, 32'd5, "R2 prio9");
    wr32(16'h009C, 32'd3, "R2 prio39");
    rd32(16'h009C, 32'd3, "R2 last source readback");
    rd32(16'h0024, 32'd5, "R2 prio9 readback");
    wr32(16'h0000, 32'd7, "R3 write source 0");
    rd32(16'h0000, 32'd0, "R3 source 0 reads zero");
    wr32(16'h00A0, 32'd6, "R3 write id NSRC");
    rd32(16'h00A0, 32'd0, "R3 id NSRC reads zero");

    // enables
    wr32(16'h2000, 32'hFFFF_FFFF, "R4 enable word0");
    rd32(16'h2000, 32'hFFFF_FFFE, "R4 bit 0 forced low");
    wr32(16'h2004, 32'hFFFF_FFFF, "R4 enable word1");
    rd32(16'h2004, 32'h0000_00FF, "R4 bits past NSRC read zero");

    // reserved space
    wr32(16'h2008, 32'd1, "R5 write enable word2");
    rd32(16'h2008, 32'd0, "R5 enable word2 reads zero");
    wr32(16'h8008, 32'd5, "R5 write context offset 8");
    rd32(16'h8008, 32'd0, "R5 context offset 8 reads zero");
    rd32(16'h8200, 32'd0, "R5 context 2 reads zero");
    rd32(16'h5000, 32'd0, "R5 unmapped reads zero");
    rd32(16'h0016, 32'd0, "R5 misaligned reads zero");
    wr32(16'h0015, 32'd1, "R5 misaligned write");
    rd32(16'h0014, 32'd7, "R5 misaligned write ignored");

    // threshold
    wr32(16'h8000, 32'hF, "R6 write threshold");
    rd32(16'h8000, 32'd7, "R6 threshold masked");
    wr32(16'h8000, 32'd1, "R6 threshold 1");
    rd32(16'h8000, 32'd1, "R6 threshold readback");

    // size rejection
    bus(1'b0, 2'd0, 16'h0014, 64'd0, 64'd0, 1'b1, "R10 byte read rejected");
    bus(1'b1, 2'd1, 16'h0014, 64'd1, 64'd0, 1'b1, "R10 half write rejected");
    rd32(16'h0014, 32'd7, "R10 rejected write no effect");
    drain();
    check("R9 irq low with nothing pending", 64'(irq_ctx), 64'd0);

    // claims
    pulse(sbit(3) | sbit(7) | sbit(9));
    drain();
    check("R9 irq ctx0 only", 64'(irq_ctx), 64'd1);
    rd32(16'h8004, 32'd9, "R7 highest priority first");
    rd32(16'h8004, 32'd3, "R7 tie to lowest id");
    rd32(16'h8004, 32'd7, "R7 remaining source");
    rd32(16'h8004, 32'd0, "R7 empty claim is zero");
    drain();
    check("R9 irq low after all claimed", 64'(irq_ctx), 64'd0);

    pulse(sbit(3));
    drain();
    rd32(16'h8004, 32'd0, "R8 in-service source ignores pulse");
    wr32(16'h8004, 32'd3, "R8 complete 3");
    wr32(16'h8004, 32'd7, "R8 complete 7");
    wr32(16'h8004, 32'd9, "R8 complete 9");
    wr32(16'h8000, 32'd2, "R7 threshold 2");
    drain();
    pulse(sbit(3));
    drain();
    check("R7 priority equal to threshold masked", 64'(irq_ctx), 64'd0);
    rd32(16'h8004, 32'd0, "R7 threshold blocks claim");
    wr32(16'h8000, 32'd1, "R7 threshold 1 again");
    drain();
    check("R9 irq after threshold lowered", 64'(irq_ctx), 64'd1);
    rd32(16'h8004, 32'd3, "R7 claim after threshold lowered");
    drain();
    pulse(sbit(3));
    drain();
    rd32(16'h8004, 32'd0, "R8 still in service");
    wr32(16'h8104, 32'd3, "R8 complete via other context");
    wr32(16'h8004, 32'd0, "R8 complete of id 0 ignored");
    drain();
    pulse(sbit(3));
    drain();
    rd32(16'h8004, 32'd3, "R8 re-armed after complete");
    wr32(16'h8004, 32'd3, "R8 complete 3 again");
    drain();

    pulse(sbit(5));
    drain();
    check("R9 ctx1 without enables stays low", 64'(irq_ctx), 64'd1);
    rd32(16'h8104, 32'd0, "R7 ctx1 claim is zero");

    // double-word accesses
    bus(1'b0, 2'd3, 16'h8000, 64'd0, {32'd5, 32'd1}, 1'b0, "R11 threshold low claim high");
    drain();
    check("R9 irq low after dword claim", 64'(irq_ctx), 64'd0);
    bus(1'b1, 2'd3, 16'h0010, {32'd6, 32'd3}, 64'd0, 1'b0, "R11 dword prio write");
    bus(1'b0, 2'd3, 16'h0010, 64'd0, {32'd6, 32'd3}, 1'b0, "R11 dword prio read");
    bus(1'b1, 2'd3, 16'h8000, {32'd5, 32'd0}, 64'd0, 1'b0, "R11 threshold then complete");
    rd32(16'h8000, 32'd0, "R11 low half threshold written");
    bus(1'b0, 2'd3, 16'h009C, 64'd0, {32'd0, 32'd3}, 1'b0, "R11 dword crossing NSRC");
    bus(1'b0, 2'd3, 16'h2000, 64'd0, {32'h0000_00FF, 32'hFFFF_FFFE}, 1'b0, "R11 dword enable read");
    drain();
    pulse(sbit(4) | sbit(5));
    drain();
    rd32(16'h8004, 32'd5, "R8 completed by dword high half");
    rd32(16'h8004, 32'd4, "R7 lower priority next");
    drain();
    check("R12 scoreboard empty", 64'(exp_d.size()), 64'd0);
    finish_run();
  end

endmodule